// File: doc/BRIEF.md
# Registered Bidirectional Parity Transceiver

This block is an octal, two-direction data port. Each transfer direction has its own holding register. The forward register captures A-side data and presents it on the B side, together with a generated parity bit. The reverse register captures B-side data and an incoming parity bit, and presents the data on the A side together with a parity check result. Each direction has its own load strobe, its own active-low load enable and its own active-low output enable. Tri-state pins appear as separate data-out and drive-enable signals.

Each direction also carries a handshake flag for demand-response transfers. Loading a register raises its flag. The consumer lowers the flag by releasing that direction's output enable after it has read the data, which is a low-to-high transition. Everything runs on one system clock. The register strobes are synchronous qualifiers sampled on that clock.

Top module: `xcvr_parity_port`

## Requirements
- R1: When `fwd_stb` is 1 and `fwd_ld_n` is 0 at a clock edge, the forward register takes `a_in`. At any other edge it holds its value.
- R2: When `rev_stb` is 1 and `rev_ld_n` is 0 at a clock edge, the reverse register takes `b_in` and the parity register takes `par_in`. At any other edge both hold.
- R3: A load of the forward register sets `fwd_flag` to 1 at that edge. A load of the reverse register sets `rev_flag` to 1 at that edge.
- R4: `fwd_flag` is cleared at the first edge where `b_en_n` is 1 after it was 0 at the previous edge. `rev_flag` is cleared in the same way by `a_en_n`.
- R5: While `b_en_n` is 0, `b_oe` and `par_oe` are 1 and `b_out` equals the forward register. While `b_en_n` is 1, `b_oe` and `par_oe` are 0.
- R6: `par_out` is 1 when the forward register holds an even number of ones, all zeros included. It is 0 otherwise.
- R7: While `a_en_n` is 0, `a_oe` is 1 and `a_out` equals the reverse register. While `a_en_n` is 1, `a_oe` is 0.
- R8: While `a_en_n` is 0, `err_n` is 1 when the reverse register plus the parity register hold an odd number of ones. It is 0 when they hold an even number, which marks a parity fault.
- R9: While `a_en_n` is 1, `err_n` is 1 and `err_oe` is 0. While `a_en_n` is 0, `err_oe` is 1.
- R10: A synchronous reset (`rst` = 1 at an edge) clears both data registers, the parity register and both flags.
- R11: When a load and a flag clear fall on the same edge in one direction, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | A-side data into the forward register |
| fwd_stb | input | 1 | Forward register load strobe |
| fwd_ld_n | input | 1 | Forward load enable, active low |
| b_en_n | input | 1 | B-side output enable, active low; its release clears `fwd_flag` |
| b_in | input | 8 | B-side data into the reverse register |
| par_in | input | 1 | Received parity bit |
| rev_stb | input | 1 | Reverse register load strobe |
| rev_ld_n | input | 1 | Reverse load enable, active low |
| a_en_n | input | 1 | A-side output enable, active low; its release clears `rev_flag` |
| a_out | output | 8 | A-side drive data |
| a_oe | output | 1 | A-side drive enable |
| b_out | output | 8 | B-side drive data |
| b_oe | output | 1 | B-side drive enable |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Parity pin drive enable |
| err_n | output | 1 | Parity check result, low on fault |
| err_oe | output | 1 | Check pin drive enable |
| fwd_flag | output | 1 | A-to-B data-waiting flag |
| rev_flag | output | 1 | B-to-A data-waiting flag |

## Verification
Register contents and flag sets show up one clock edge after the qualifying strobe. A flag clear lands on the edge that sees the enable high for the first time after it was low. The drive data, parity, check result and drive enables follow the output enables and the register contents combinationally, within the same cycle. The bench changes inputs only on falling edges. It checks the registered results at the next falling edge, after exactly one rising edge has passed. It checks the combinational results shortly after the enables change, before any further rising edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_W = 8;

    // Per-direction control bundle
    typedef struct packed {
        logic stb;    // synchronous load strobe
        logic ld_n;   // active-low load enable
        logic en_n;   // active-low output enable
    } dir_ctl_t;

    function automatic logic load_req(dir_ctl_t c);
        return c.stb & ~c.ld_n;
    endfunction

    function automatic logic release_edge(logic en_now_n, logic en_prev_n);
        return en_now_n & ~en_prev_n;
    endfunction

endpackage

// File: rtl/xcvr_par_unit.sv
module xcvr_par_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    output logic         odd
);
    localparam int HALF = W / 2;

    generate
        if (W == 1) begin : g_leaf
            assign odd = vec[0];
        end else begin : g_split
            logic lo_odd, hi_odd;
            xcvr_par_unit #(.W(HALF))     u_lo (.vec(vec[HALF-1:0]), .odd(lo_odd));
            xcvr_par_unit #(.W(W - HALF)) u_hi (.vec(vec[W-1:HALF]), .odd(hi_odd));
            assign odd = lo_odd ^ hi_odd;
        end
    endgenerate
endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  dir_ctl_t       ctl,
    input  logic [W-1:0]   d,
    output logic [W-1:0]   q,
    output logic           flag
);
    logic en_prev_n;
    logic load, rel;

    assign load = load_req(ctl);
    assign rel  = release_edge(ctl.en_n, en_prev_n);

    // Enable history follows the pin even in reset, so the release
    // detector never sees a stale value.
    always_ff @(posedge clk) en_prev_n <= ctl.en_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            flag <= 1'b0;
        end else begin
            if (load) q <= d;
            if (load)      flag <= 1'b1;   // set has priority
            else if (rel)  flag <= 1'b0;
        end
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (ctl.stb && !ctl.ld_n) |=> (q == $past(d)));                      // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(ctl.stb && !ctl.ld_n) |=> $stable(q));                          // R2
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (ctl.stb && !ctl.ld_n) |=> flag);                                 // R3
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctl.en_n) && !(ctl.stb && !ctl.ld_n)) |=> !flag);         // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctl.en_n) && ctl.stb && !ctl.ld_n) |=> flag);              // R11
endmodule

// File: rtl/xcvr_parity_port.sv
module xcvr_parity_port
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic         fwd_stb,
    input  logic         fwd_ld_n,
    input  logic         b_en_n,
    input  logic [W-1:0] b_in,
    input  logic         par_in,
    input  logic         rev_stb,
    input  logic         rev_ld_n,
    input  logic         a_en_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         par_out,
    output logic         par_oe,
    output logic         err_n,
    output logic         err_oe,
    output logic         fwd_flag,
    output logic         rev_flag
);
    localparam int RW = W + 1;   // reverse data plus parity bit

    dir_ctl_t     fwd_ctl, rev_ctl;
    logic [W-1:0] fwd_q;
    logic [RW-1:0] rev_q;
    logic         fwd_odd, rev_odd;

    assign fwd_ctl = '{stb: fwd_stb, ld_n: fwd_ld_n, en_n: b_en_n};
    assign rev_ctl = '{stb: rev_stb, ld_n: rev_ld_n, en_n: a_en_n};

    xcvr_hold_reg #(.W(W)) u_fwd (
        .clk(clk), .rst(rst), .ctl(fwd_ctl), .d(a_in),
        .q(fwd_q), .flag(fwd_flag)
    );

    xcvr_hold_reg #(.W(RW)) u_rev (
        .clk(clk), .rst(rst), .ctl(rev_ctl), .d({par_in, b_in}),
        .q(rev_q), .flag(rev_flag)
    );

    xcvr_par_unit #(.W(W))  u_gen (.vec(fwd_q), .odd(fwd_odd));
    xcvr_par_unit #(.W(RW)) u_chk (.vec(rev_q), .odd(rev_odd));

    // B side: data and generated parity
    assign b_out   = fwd_q;
    assign b_oe    = ~b_en_n;
    assign par_out = ~fwd_odd;
    assign par_oe  = ~b_en_n;

    // A side: data and check result
    assign a_out  = rev_q[W-1:0];
    assign a_oe   = ~a_en_n;
    assign err_n  = a_en_n ? 1'b1 : rev_odd;
    assign err_oe = ~a_en_n;

    AST_B_DRIVE: assert property (@(posedge clk) disable iff (rst)
        b_en_n |-> (!b_oe && !par_oe));                                   // R5
    AST_PAR_SENSE: assert property (@(posedge clk) disable iff (rst)
        (par_out == ($countones(b_out) % 2 == 0)));                       // R6
    AST_A_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !a_en_n |-> a_oe);                                                // R7
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        a_en_n |-> (err_n && !err_oe));                                   // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!fwd_flag && !rev_flag && b_out == '0 && a_out == '0)); // R10
endmodule

// File: tb/xcvr_parity_port_test.sv
module xcvr_parity_port_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] a_in, b_in;
    logic       par_in, fwd_stb, fwd_ld_n, b_en_n, rev_stb, rev_ld_n, a_en_n;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe, par_out, par_oe, err_n, err_oe, fwd_flag, rev_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xcvr_parity_port uut (
        .clk(clk), .rst(rst), .a_in(a_in), .fwd_stb(fwd_stb), .fwd_ld_n(fwd_ld_n),
        .b_en_n(b_en_n), .b_in(b_in), .par_in(par_in), .rev_stb(rev_stb),
        .rev_ld_n(rev_ld_n), .a_en_n(a_en_n), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe), .par_out(par_out), .par_oe(par_oe),
        .err_n(err_n), .err_oe(err_oe), .fwd_flag(fwd_flag), .rev_flag(rev_flag)
    );

    // {a, b, parity-in}
    localparam logic [16:0] VEC [8] = '{
        {8'h00, 8'h00, 1'b1}, {8'hFF, 8'hFF, 1'b0}, {8'h01, 8'h01, 1'b0},
        {8'hA5, 8'hA5, 1'b1}, {8'h7F, 8'h7F, 1'b0}, {8'h3C, 8'h3C, 1'b0},
        {8'h80, 8'h0E, 1'b1}, {8'hC3, 8'hD5, 1'b0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        fwd_stb = 0; fwd_ld_n = 1; rev_stb = 0; rev_ld_n = 1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; a_in = 0; b_in = 0; par_in = 0; b_en_n = 1; a_en_n = 1;
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state
        check("R10 fwd_flag", fwd_flag, 0);
        check("R10 rev_flag", rev_flag, 0);
        b_en_n = 0; a_en_n = 0; #1;
        check("R10 b_out", b_out, 0);
        check("R10 a_out", a_out, 0);
        @(negedge clk); b_en_n = 1; a_en_n = 1;
        @(negedge clk);

        // Vector table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ea, eb;
            logic       ep;
            {ea, eb, ep} = VEC[i];
            a_in = ea; b_in = eb; par_in = ep;
            fwd_stb = 1; fwd_ld_n = 0; rev_stb = 1; rev_ld_n = 0;
            @(negedge clk);
            idle();
            check("R3 fwd_flag set", fwd_flag, 1);
            check("R3 rev_flag set", rev_flag, 1);
            b_en_n = 0; a_en_n = 0; #1;
            check("R1 b_out", b_out, ea);
            check("R5 b_oe", b_oe, 1);
            check("R5 par_oe", par_oe, 1);
            check("R6 par_out", par_out, ~^ea);
            check("R2 R7 a_out", a_out, eb);
            check("R7 a_oe", a_oe, 1);
            check("R8 err_n", err_n, ^{eb, ep});
            check("R9 err_oe", err_oe, 1);
            @(negedge clk); b_en_n = 1; a_en_n = 1;
            @(negedge clk);
            check("R4 fwd_flag cleared", fwd_flag, 0);
            check("R4 rev_flag cleared", rev_flag, 0);
        end

        // R1 R2 hold: strobe with enable high, then enable low without strobe
        a_in = 8'h55; b_in = 8'hAA; par_in = 1;
        fwd_stb = 1; fwd_ld_n = 1; rev_stb = 1; rev_ld_n = 1;
        @(negedge clk);
        fwd_stb = 0; fwd_ld_n = 0; rev_stb = 0; rev_ld_n = 0;
        @(negedge clk);
        idle();
        check("R3 no flag without load", fwd_flag, 0);
        b_en_n = 0; a_en_n = 0; #1;
        check("R1 hold b_out", b_out, 8'hC3);
        check("R2 hold a_out", a_out, 8'hD5);
        check("R2 hold parity reg via err_n", err_n, 1);
        @(negedge clk); b_en_n = 1; a_en_n = 1;
        @(negedge clk);

        // R8 fault and R9 disabled check output
        b_in = 8'h03; par_in = 0; rev_stb = 1; rev_ld_n = 0;
        @(negedge clk);
        idle(); #1;
        check("R9 err_n idle", err_n, 1);
        check("R9 err_oe idle", err_oe, 0);
        check("R7 a_oe idle", a_oe, 0);
        check("R5 b_oe idle", b_oe, 0);
        check("R5 par_oe idle", par_oe, 0);
        a_en_n = 0; #1;
        check("R8 err_n fault", err_n, 0);
        @(negedge clk); a_en_n = 1;
        @(negedge clk);

        // R11 load and release on one edge: set wins
        a_in = 8'h11; fwd_stb = 1; fwd_ld_n = 0;
        @(negedge clk);
        idle(); b_en_n = 0;
        @(negedge clk);
        b_en_n = 1; a_in = 8'h99; fwd_stb = 1; fwd_ld_n = 0;
        @(negedge clk);
        idle();
        check("R11 flag kept", fwd_flag, 1);
        b_en_n = 0; #1;
        check("R11 new data", b_out, 8'h99);
        @(negedge clk); b_en_n = 1;
        @(negedge clk);
        check("R4 flag cleared after release", fwd_flag, 0);

        // R10 reset mid-operation
        a_in = 8'h5A; b_in = 8'hA5; par_in = 1;
        fwd_stb = 1; fwd_ld_n = 0; rev_stb = 1; rev_ld_n = 0;
        @(negedge clk);
        idle(); rst = 1;
        @(negedge clk);
        rst = 0;
        check("R10 fwd_flag", fwd_flag, 0);
        check("R10 rev_flag", rev_flag, 0);
        b_en_n = 0; a_en_n = 0; #1;
        check("R10 b_out", b_out, 0);
        check("R10 a_out", a_out, 0);
        check("R10 parity reg via err_n", err_n, 0);
        @(negedge clk); b_en_n = 1; a_en_n = 1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule